// File: doc/BRIEF.md
# Dual-Modulus Feedback Divider Controller

This block is the programmable feedback divider of a frequency synthesizer that drives an external dual-modulus prescaler (divide by P or P+1). It is clocked by the prescaler's output edges. Two down-counters share one division period. The main counter takes a 10-bit value N and sets the length of the period in prescaler edges. The swallow counter takes a 6-bit value A and holds the modulus-control line at P+1 for the first A edges of the period. For the remaining N−A edges the line selects P. The input-side division is therefore N·P + A, and one feedback pulse per period goes to the phase detector.

Both values come from static parallel pins. The block reads them only on the edge that starts a new period, so the pins may change at any time without disturbing a period in progress. The block has no data stream, only control pins, so it has no valid/ready handshake. The modulus line and the pulse are plain levels. Each is valid for one prescaler-edge interval and changes only on that clock.

Top module: `dual_mod_fbdiv`

## Requirements
- R1: While `rst_n` is low, and until the first `clk` edge after it rises, `mod_sel` and `fb_pulse` are 0. That first edge loads N and A and starts a period.
- R2: For N ≥ 2, `fb_pulse` is 1 for exactly one `clk` interval per period: the last of the N intervals. The next edge starts a new period.
- R3: In a period with 0 < A ≤ N, `mod_sel` is 1 (select P+1) for the first A intervals and 0 (select P) for the remaining N−A intervals, giving a division of N·P + A.
- R4: When A = 0, `mod_sel` stays 0 for the whole period.
- R5: When A > N, A is limited to N, so `mod_sel` stays 1 for the whole period.
- R6: An N of 0 or 1 gives a period of one interval: `fb_pulse` is 1 on every interval, and `mod_sel` is 1 exactly when A ≠ 0.
- R7: The pins are sampled only on the edge that starts a period. Pin changes during a period have no effect until the next period begins.
- R8: Back-to-back periods with different N and A follow one another with no idle interval between them.
- R9: The full ranges apply: N up to 1023 (10 bits) and A up to 63 (6 bits).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Prescaler output edges (rising edge active) |
| rst_n | input | 1 | Asynchronous active-low reset |
| n_pins | input | 10 | Main count N, parallel static input |
| a_pins | input | 6 | Swallow count A, parallel static input |
| mod_sel | output | 1 | 1 selects P+1, 0 selects P |
| fb_pulse | output | 1 | One-interval feedback pulse per division period |

## Verification
A scoreboard predicts each interval's `mod_sel` and `fb_pulse` from N and A and compares them against the design. The corner cases are:
- A = 0: a design that got it wrong would pulse the modulus line for one interval.
- A > N: a design that got it wrong would wrap the swallow count into the next period.
- N of 0 or 1: a design that got it wrong would count through 1024 edges or stall with no pulse.
- N = 1023 with A = 63: checks that no bit of either count is lost.

Pins that change in the middle of a period must be ignored. A design that re-read them would shorten or lengthen the period it is in. Periods that change N and A back to back expose an off-by-one at the reload edge, which would show up as an extra or a missing interval.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;
  localparam int unsigned MAIN_W_DEF = 10;
  localparam int unsigned SWAL_W_DEF = 6;

  typedef enum logic [0:0] {
    MOD_LOW  = 1'b0,  // prescaler divides by P
    MOD_HIGH = 1'b1   // prescaler divides by P+1
  } mod_e;
endpackage

// File: rtl/fbdiv_load_calc.sv
module fbdiv_load_calc #(
  parameter int unsigned MAIN_W = 10,
  parameter int unsigned SWAL_W = 6
) (
  input  logic [MAIN_W-1:0] n_raw,
  input  logic [SWAL_W-1:0] a_raw,
  output logic [MAIN_W-1:0] n_eff,
  output logic [MAIN_W-1:0] a_eff
);
  logic [MAIN_W-1:0] a_wide;

  // Bring the swallow value to the main width; a variant per width relation.
  generate
    if (SWAL_W < MAIN_W) begin : g_ext
      assign a_wide = {{(MAIN_W-SWAL_W){1'b0}}, a_raw};
    end else begin : g_trunc
      assign a_wide = a_raw[MAIN_W-1:0];
    end
  endgenerate

  always_comb begin
    // A zero main count behaves as a one-interval period.
    n_eff = (n_raw == '0) ? {{(MAIN_W-1){1'b0}}, 1'b1} : n_raw;
    // Swallow count never exceeds the period length.
    a_eff = (a_wide > n_eff) ? n_eff : a_wide;
  end
endmodule

// File: rtl/fbdiv_main_cnt.sv
module fbdiv_main_cnt #(
  parameter int unsigned MAIN_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [MAIN_W-1:0] load_val,
  output logic              terminal
);
  logic [MAIN_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= {{(MAIN_W-1){1'b0}}, 1'b1};
    else if (load)   cnt_q <= load_val;
    else             cnt_q <= cnt_q - 1'b1;
  end

  assign terminal = (cnt_q == {{(MAIN_W-1){1'b0}}, 1'b1});
endmodule

// File: rtl/fbdiv_swallow_cnt.sv
module fbdiv_swallow_cnt #(
  parameter int unsigned MAIN_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [MAIN_W-1:0] load_val,
  output logic              active
);
  logic [MAIN_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign active = (cnt_q != '0);
endmodule

// File: rtl/dual_mod_fbdiv.sv
module dual_mod_fbdiv
  import fbdiv_pkg::*;
#(
  parameter int unsigned MAIN_W = MAIN_W_DEF,
  parameter int unsigned SWAL_W = SWAL_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MAIN_W-1:0] n_pins,
  input  logic [SWAL_W-1:0] a_pins,
  output logic              mod_sel,
  output logic              fb_pulse
);
  logic [MAIN_W-1:0] n_eff, a_eff;
  logic              terminal, swallow_on, reload;
  logic              primed_q;
  mod_e              mod_now;

  fbdiv_load_calc #(.MAIN_W(MAIN_W), .SWAL_W(SWAL_W)) u_calc (
    .n_raw (n_pins),
    .a_raw (a_pins),
    .n_eff (n_eff),
    .a_eff (a_eff)
  );

  // Pins are consumed only on the edge that opens a period.
  assign reload = !primed_q || terminal;

  fbdiv_main_cnt #(.MAIN_W(MAIN_W)) u_main (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (reload),
    .load_val (n_eff),
    .terminal (terminal)
  );

  fbdiv_swallow_cnt #(.MAIN_W(MAIN_W)) u_swal (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (reload),
    .load_val (a_eff),
    .active   (swallow_on)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed_q <= 1'b0;
    else        primed_q <= 1'b1;
  end

  assign mod_now  = (primed_q && swallow_on) ? MOD_HIGH : MOD_LOW;
  assign mod_sel  = (mod_now == MOD_HIGH);
  assign fb_pulse = primed_q && terminal;
endmodule

// File: rtl/dual_mod_fbdiv_chk.sv
module dual_mod_fbdiv_chk #(
  parameter int unsigned MAIN_W = 10,
  parameter int unsigned SWAL_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [MAIN_W-1:0] n_pins,
  input logic [SWAL_W-1:0] a_pins,
  input logic              mod_sel,
  input logic              fb_pulse,
  input logic              primed_q
);
  logic              start;
  logic [MAIN_W:0]   gap_q;
  logic [MAIN_W:0]   len_q;

  assign start = !primed_q || fb_pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= '0;
      len_q <= '0;
    end else if (start) begin
      gap_q <= 1;
      len_q <= (n_pins == '0) ? 1 : {1'b0, n_pins};
    end else begin
      gap_q <= gap_q + 1'b1;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) assert_reset_quiet_R1: assert (!mod_sel && !fb_pulse);
  end

  assert_pulse_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && fb_pulse) |-> (gap_q == len_q));

  assert_mod_monotone_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && !mod_sel && !fb_pulse) |=> !mod_sel);

  assert_zero_swallow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && a_pins == '0) |=> !mod_sel);

  assert_swallow_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && a_pins != '0) |=> mod_sel);

  assert_short_period_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && n_pins <= 1) |=> fb_pulse);
endmodule

bind dual_mod_fbdiv dual_mod_fbdiv_chk #(.MAIN_W(MAIN_W), .SWAL_W(SWAL_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .n_pins   (n_pins),
  .a_pins   (a_pins),
  .mod_sel  (mod_sel),
  .fb_pulse (fb_pulse),
  .primed_q (primed_q)
);

// File: tb/test_dual_mod_fbdiv.sv
module test_dual_mod_fbdiv;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] n_pins = '0;
  logic [5:0] a_pins = '0;
  logic       mod_sel, fb_pulse;

  int errors = 0;
  int checks = 0;
  bit armed = 1'b0;
  bit done = 1'b0;

  typedef struct {
    bit    mod;
    bit    fb;
    string tag;
  } item_t;
  item_t q[$];

  always #5 clk = ~clk;

  dual_mod_fbdiv i_dual_mod_fbdiv (
    .clk(clk), .rst_n(rst_n), .n_pins(n_pins), .a_pins(a_pins),
    .mod_sel(mod_sel), .fb_pulse(fb_pulse)
  );

  task automatic check(input string tag, input bit got_m, input bit got_f,
                       input bit exp_m, input bit exp_f);
    checks++;
    if (got_m !== exp_m || got_f !== exp_f) begin
      errors++;
      $display("FAIL %s: mod_sel=%0b fb_pulse=%0b expected mod_sel=%0b fb_pulse=%0b at %0t",
               tag, got_m, got_f, exp_m, exp_f, $time);
    end
  endtask

  // Monitor: one expected item per interval.
  always @(negedge clk) begin
    if (armed && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check(it.tag, mod_sel, fb_pulse, it.mod, it.fb);
    end
  end

  // Driver: called at a negedge inside the last interval of the previous
  // period (or during reset). Sets pins and queues the whole period.
  task automatic do_period(input int n, input int a, input string tag,
                           input bit wiggle);
    int ne, ae;
    n_pins = n[9:0];
    a_pins = a[5:0];
    ne = (n == 0) ? 1 : n;
    ae = (a > ne) ? ne : a;
    for (int k = 0; k < ne; k++) begin
      item_t it;
      it.mod = (k < ae);
      it.fb  = (k == ne - 1);
      it.tag = tag;
      q.push_back(it);
    end
    for (int k = 0; k < ne; k++) begin
      @(negedge clk);
      if (wiggle && k == 0 && ne > 2) begin
        n_pins = 10'd3;   // R7: mid-period change must be ignored
        a_pins = 6'd1;
      end
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", mod_sel, fb_pulse, 1'b0, 1'b0);
    n_pins = 10'd10;
    a_pins = 6'd3;
    rst_n  = 1'b1;
    check("R1 after release before edge", mod_sel, fb_pulse, 1'b0, 1'b0);
    fork
      begin @(posedge clk); armed = 1'b1; end
      do_period(10, 3, "R3 N=10 A=3", 1'b0);
    join
    do_period(10, 0, "R4 A=0", 1'b0);
    do_period(5, 5, "R3 A=N", 1'b0);
    do_period(4, 9, "R5 A>N", 1'b0);
    do_period(1, 0, "R6 N=1 A=0", 1'b0);
    do_period(0, 2, "R6 N=0 A=2", 1'b0);
    do_period(1, 1, "R6 N=1 A=1", 1'b0);
    do_period(20, 7, "R7 pins wiggled", 1'b1);
    do_period(2, 1, "R2 N=2", 1'b0);
    do_period(1023, 63, "R9 full range", 1'b0);
    do_period(6, 2, "R8 back to back", 1'b0);
    do_period(7, 3, "R8 back to back", 1'b0);
    while (q.size() > 0) @(negedge clk);
    armed = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R1 reset mid-run", mod_sel, fb_pulse, 1'b0, 1'b0);
    @(negedge clk);
    check("R1 held reset", mod_sel, fb_pulse, 1'b0, 1'b0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule